// File: doc/BRIEF.md
# Time-Slotted Operand Collector

This block sits between a four-lane arithmetic pipeline and a register storage built from one single-ported array of 256-bit rows. Each row packs four 64-bit registers, so one access moves a whole group, lane 0 in bits 63:0 up to lane 3 in bits 255:192. A free-running four-cycle rotation decides what the storage port does in every cycle. Slot 0 reads the first source group, slot 1 the second and slot 2 the third. Slot 3 writes one finished result group. Because reads and writes live in different slots, a single port is enough and the storage never sees a read and a write together.

Collector flip-flops hold the three source groups. In slot 3 the four lanes receive their operands at once. A fixed-latency stub stands in for the multiply-add units: it computes `a*b + c` per lane and delays the result by four cycles. The result then reaches the write slot of the following rotation. An instruction that needs no third source leaves slot 2 free, and a pending memory request takes it. A store reads a row through the port. A load writes a row through the port. Requests that do not get the slot wait for a later one.

The block does not check for data hazards. A group written by one instruction can be read as a source from the second rotation after its issue onward.

Top module: `opcol_top`

## Requirements
- R1: After reset the slot number counts 0,1,2,3 and wraps, one step per cycle. The first cycle after reset is slot 0, and `issue_ready` is high exactly in slot 0.
- R2: `issue_valid` is sampled only in slot 0. A high `issue_valid` in slots 1 to 3 starts nothing, so no row is written.
- R3: For each lane l (bits 64l+63:64l) the result is the low 64 bits of `a*b + c`. Here a, b and c are lane l of rows `issue_src1`, `issue_src2` and `issue_src3`. When `issue_use_src3` is 0, c is taken as zero.
- R4: An instruction accepted in cycle t writes its result row `issue_dst` at the end of cycle t+7, which is the slot 3 of the next rotation. A store granted in cycle t+6 returns the old contents, and one granted in cycle t+10 returns the new contents.
- R5: Instructions issued in consecutive rotations each write their own result, one write per four cycles.
- R6: The storage port never reads and writes in the same cycle. A load in slot 2 and a result write in the following slot 3 both take effect.
- R7: `mem_grant` is high only in slot 2 and only with `mem_req_valid` high. It stays low when the instruction being collected uses a third source. An ungranted request held high is granted in a later slot 2 that is free.
- R8: A granted load (`mem_req_store` = 0) writes `mem_req_wdata` into row `mem_req_row` at the end of the grant cycle.
- R9: A granted store (`mem_req_store` = 1) sets `mem_rdata_valid` high for the next cycle only, with `mem_rdata` equal to row `mem_req_row`.
- R10: Reset clears every collector and pipeline valid flag. An instruction in flight when reset is applied writes nothing. Row contents are kept across reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| issue_valid | input | 1 | Instruction offered |
| issue_ready | output | 1 | High in slot 0, where an offer is taken |
| issue_src1 | input | ROW_AW | Row of the first source group |
| issue_src2 | input | ROW_AW | Row of the second source group |
| issue_src3 | input | ROW_AW | Row of the third source group |
| issue_use_src3 | input | 1 | Instruction uses a third source |
| issue_dst | input | ROW_AW | Row that receives the result group |
| mem_req_valid | input | 1 | Memory request pending, held until granted |
| mem_req_store | input | 1 | 1 = store (row read), 0 = load (row write) |
| mem_req_row | input | ROW_AW | Row addressed by the memory request |
| mem_req_wdata | input | 256 | Load data |
| mem_grant | output | 1 | Request takes the storage port this cycle |
| mem_rdata | output | 256 | Row read for a store |
| mem_rdata_valid | output | 1 | `mem_rdata` valid this cycle |

## Verification
A memory request and a third-operand read can both want slot 2. The bench raises a request in the very cycle it issues a three-source instruction. It then judges that the grant stays low in that rotation's slot 2 and arrives in the next free one. In a second case a load is held back this way into the slot just before a result write. The bench checks that both the loaded row and the result row hold their expected values afterwards.

// File: rtl/opcol_pkg.sv
package opcol_pkg;
  localparam int XLEN   = 64;
  localparam int LANES  = 4;
  localparam int ROW_W  = XLEN * LANES;
  localparam int SLOTS  = 4;
  localparam int SLOT_W = $clog2(SLOTS);

  localparam logic [SLOT_W-1:0] SLOT_RD_A = 2'd0;
  localparam logic [SLOT_W-1:0] SLOT_RD_B = 2'd1;
  localparam logic [SLOT_W-1:0] SLOT_RD_C = 2'd2;
  localparam logic [SLOT_W-1:0] SLOT_WB   = 2'd3;

  // Per-lane arithmetic of the stub: low XLEN bits of a*b+c.
  function automatic logic [XLEN-1:0] lane_madd(input logic [XLEN-1:0] a,
                                                input logic [XLEN-1:0] b,
                                                input logic [XLEN-1:0] c);
    logic [XLEN-1:0] prod;
    prod = a * b;
    return prod + c;
  endfunction
endpackage

// File: rtl/opcol_slot_ctr.sv
module opcol_slot_ctr
  import opcol_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  output logic [SLOT_W-1:0] slot
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) slot <= '0;
    else        slot <= slot + 1'b1;
  end
endmodule

// File: rtl/opcol_regstore.sv
module opcol_regstore #(
  parameter int AW = 5,
  parameter int W  = 256
) (
  input  logic          clk,
  input  logic [AW-1:0] addr,
  input  logic          we,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  rdata
);
  localparam int DEPTH = 1 << AW;
  logic [W-1:0] rows [DEPTH];

  assign rdata = rows[addr];

  always_ff @(posedge clk) begin
    if (we) rows[addr] <= wdata;
  end
endmodule

// File: rtl/opcol_lanes.sv
module opcol_lanes
  import opcol_pkg::*;
#(
  parameter int AW     = 5,
  parameter int STAGES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [AW-1:0]    in_dst,
  input  logic [ROW_W-1:0] op_a,
  input  logic [ROW_W-1:0] op_b,
  input  logic [ROW_W-1:0] op_c,
  output logic             out_valid,
  output logic [AW-1:0]    out_dst,
  output logic [ROW_W-1:0] out_data
);
  logic [ROW_W-1:0]  in_res;
  logic [STAGES-1:0] v_q;
  logic [AW-1:0]     dst_q [STAGES];
  logic [ROW_W-1:0]  dat_q [STAGES];

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign in_res[l*XLEN +: XLEN] = lane_madd(op_a[l*XLEN +: XLEN],
                                              op_b[l*XLEN +: XLEN],
                                              op_c[l*XLEN +: XLEN]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) v_q <= '0;
    else        v_q <= {v_q[STAGES-2:0], in_valid};
  end

  always_ff @(posedge clk) begin
    dst_q[0] <= in_dst;
    dat_q[0] <= in_res;
    for (int s = 1; s < STAGES; s++) begin
      dst_q[s] <= dst_q[s-1];
      dat_q[s] <= dat_q[s-1];
    end
  end

  assign out_valid = v_q[STAGES-1];
  assign out_dst   = dst_q[STAGES-1];
  assign out_data  = dat_q[STAGES-1];
endmodule

// File: rtl/opcol_top.sv
module opcol_top
  import opcol_pkg::*;
#(
  parameter int ROW_AW = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue_valid,
  output logic              issue_ready,
  input  logic [ROW_AW-1:0] issue_src1,
  input  logic [ROW_AW-1:0] issue_src2,
  input  logic [ROW_AW-1:0] issue_src3,
  input  logic              issue_use_src3,
  input  logic [ROW_AW-1:0] issue_dst,
  input  logic              mem_req_valid,
  input  logic              mem_req_store,
  input  logic [ROW_AW-1:0] mem_req_row,
  input  logic [ROW_W-1:0]  mem_req_wdata,
  output logic              mem_grant,
  output logic [ROW_W-1:0]  mem_rdata,
  output logic              mem_rdata_valid
);
  logic [SLOT_W-1:0] slot_q;
  logic              issue_accept, src3_rd, store_grant, load_grant;
  logic              rd_en, wr_en, wb_en;
  logic [ROW_AW-1:0] st_addr, wb_dst;
  logic [ROW_W-1:0]  st_wdata, st_rdata, wb_data;

  logic              col_valid, col_use3;
  logic [ROW_AW-1:0] col_src2, col_src3, col_dst;
  logic [ROW_W-1:0]  col_a, col_b, col_c, op_c_eff;

  opcol_slot_ctr u_slot (.clk(clk), .rst_n(rst_n), .slot(slot_q));

  // Slot events
  assign issue_ready  = (slot_q == SLOT_RD_A);
  assign issue_accept = issue_ready && issue_valid;
  assign src3_rd      = (slot_q == SLOT_RD_C) && col_valid && col_use3;
  assign mem_grant    = (slot_q == SLOT_RD_C) && mem_req_valid && !(col_valid && col_use3);
  assign store_grant  = mem_grant && mem_req_store;
  assign load_grant   = mem_grant && !mem_req_store;
  assign rd_en        = issue_accept || ((slot_q == SLOT_RD_B) && col_valid)
                        || src3_rd || store_grant;
  assign wr_en        = wb_en || load_grant;

  // Single storage port address and write data
  always_comb begin
    unique case (slot_q)
      SLOT_RD_A: st_addr = issue_src1;
      SLOT_RD_B: st_addr = col_src2;
      SLOT_RD_C: st_addr = src3_rd ? col_src3 : mem_req_row;
      default:   st_addr = wb_dst;
    endcase
  end
  assign st_wdata = wb_en ? wb_data : mem_req_wdata;

  opcol_regstore #(.AW(ROW_AW), .W(ROW_W)) u_store (
    .clk(clk), .addr(st_addr), .we(wr_en), .wdata(st_wdata), .rdata(st_rdata)
  );

  // Collector control flags
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col_valid       <= 1'b0;
      col_use3        <= 1'b0;
      mem_rdata_valid <= 1'b0;
    end else begin
      mem_rdata_valid <= store_grant;
      if (slot_q == SLOT_RD_A) begin
        col_valid <= issue_accept;
        col_use3  <= issue_accept && issue_use_src3;
      end
    end
  end

  // Collector data latches
  always_ff @(posedge clk) begin
    if (issue_accept) begin
      col_a    <= st_rdata;
      col_src2 <= issue_src2;
      col_src3 <= issue_src3;
      col_dst  <= issue_dst;
    end
    if (slot_q == SLOT_RD_B) col_b <= st_rdata;
    if (src3_rd)             col_c <= st_rdata;
    if (store_grant)         mem_rdata <= st_rdata;
  end

  assign op_c_eff = col_use3 ? col_c : '0;

  // Forward in the write slot; the stub depth equals the rotation length,
  // so a result leaves the stub exactly in the next write slot.
  opcol_lanes #(.AW(ROW_AW), .STAGES(SLOTS)) u_lanes (
    .clk(clk), .rst_n(rst_n),
    .in_valid((slot_q == SLOT_WB) && col_valid), .in_dst(col_dst),
    .op_a(col_a), .op_b(col_b), .op_c(op_c_eff),
    .out_valid(wb_en), .out_dst(wb_dst), .out_data(wb_data)
  );
endmodule

// File: rtl/opcol_checker.sv
module opcol_checker
  import opcol_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [SLOT_W-1:0] slot_q,
  input logic              issue_ready,
  input logic              issue_accept,
  input logic              rd_en,
  input logic              wr_en,
  input logic              wb_en,
  input logic              mem_grant,
  input logic              mem_req_valid,
  input logic              mem_req_store,
  input logic              mem_rdata_valid,
  input logic              col_valid,
  input logic              col_use3
);
  assert_slot_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> slot_q == SLOT_W'($past(slot_q) + 1'b1));

  assert_ready_slot0_R1: assert property (@(posedge clk) disable iff (!rst_n)
    issue_ready == (slot_q == SLOT_RD_A));

  assert_accept_in_slot0_R2: assert property (@(posedge clk) disable iff (!rst_n)
    issue_accept |-> slot_q == SLOT_RD_A);

  assert_wb_in_slot3_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |-> slot_q == SLOT_WB);

  assert_wb_spacing_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |=> !wb_en);

  assert_no_rd_wr_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_en && wr_en));

  assert_grant_slot2_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_grant |-> (slot_q == SLOT_RD_C) && mem_req_valid && !(col_valid && col_use3));

  assert_load_writes_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_grant && !mem_req_store) |-> wr_en);

  assert_store_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_grant && mem_req_store) |=> mem_rdata_valid);

  assert_rdv_only_after_store_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rdata_valid |-> slot_q == SLOT_WB);

  assert_reset_clears_R10: assert property (@(posedge clk)
    !rst_n |=> !col_valid && !mem_rdata_valid);
endmodule

bind opcol_top opcol_checker u_opcol_checker (
  .clk(clk), .rst_n(rst_n), .slot_q(slot_q), .issue_ready(issue_ready),
  .issue_accept(issue_accept), .rd_en(rd_en), .wr_en(wr_en), .wb_en(wb_en),
  .mem_grant(mem_grant), .mem_req_valid(mem_req_valid),
  .mem_req_store(mem_req_store), .mem_rdata_valid(mem_rdata_valid),
  .col_valid(col_valid), .col_use3(col_use3)
);

// File: tb/test_opcol_top.sv
`timescale 1ns/1ps
module test_opcol_top;
  localparam int AW = 5;
  localparam int W  = 256;

  logic clk = 1'b0;
  logic rst_n;
  logic issue_valid, issue_ready, issue_use_src3;
  logic [AW-1:0] issue_src1, issue_src2, issue_src3, issue_dst;
  logic mem_req_valid, mem_req_store, mem_grant, mem_rdata_valid;
  logic [AW-1:0] mem_req_row;
  logic [W-1:0]  mem_req_wdata, mem_rdata;

  int n_checks = 0;
  int n_fail   = 0;
  int cyc      = 0;

  always #5 clk = ~clk;

  opcol_top #(.ROW_AW(AW)) i_opcol_top (
    .clk(clk), .rst_n(rst_n),
    .issue_valid(issue_valid), .issue_ready(issue_ready),
    .issue_src1(issue_src1), .issue_src2(issue_src2), .issue_src3(issue_src3),
    .issue_use_src3(issue_use_src3), .issue_dst(issue_dst),
    .mem_req_valid(mem_req_valid), .mem_req_store(mem_req_store),
    .mem_req_row(mem_req_row), .mem_req_wdata(mem_req_wdata),
    .mem_grant(mem_grant), .mem_rdata(mem_rdata), .mem_rdata_valid(mem_rdata_valid)
  );

  task automatic summary();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: run hung, actual %0d cycles expected < 20000", cyc);
      summary();
    end
  end

  task automatic chk(input bit ok, input string req, input logic [W-1:0] act,
                     input logic [W-1:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] pat(input int r);
    logic [W-1:0] v;
    for (int l = 0; l < 4; l++)
      v[l*64 +: 64] = 64'hA5A5_0000_0000_0001 * 64'(r + 1) + 64'(l * 13 + 5);
    return v;
  endfunction

  // Expected lane results restated from R3
  function automatic logic [W-1:0] madd_row(input logic [W-1:0] a, input logic [W-1:0] b,
                                            input logic [W-1:0] c, input bit use_c);
    logic [W-1:0] v;
    for (int l = 0; l < 4; l++) begin
      logic [127:0] full;
      full = {64'd0, a[l*64 +: 64]} * {64'd0, b[l*64 +: 64]};
      v[l*64 +: 64] = full[63:0] + (use_c ? c[l*64 +: 64] : 64'd0);
    end
    return v;
  endfunction

  task automatic sync_slot0();
    @(negedge clk);
    while (!issue_ready) @(negedge clk);
  endtask

  task automatic mem_load(input int row, input logic [W-1:0] d);
    @(negedge clk);
    mem_req_valid = 1'b1; mem_req_store = 1'b0;
    mem_req_row = AW'(row); mem_req_wdata = d;
    while (!mem_grant) @(negedge clk);
    @(negedge clk);
    mem_req_valid = 1'b0;
  endtask

  task automatic mem_store(input int row, output logic [W-1:0] d, output bit v);
    @(negedge clk);
    mem_req_valid = 1'b1; mem_req_store = 1'b1; mem_req_row = AW'(row);
    while (!mem_grant) @(negedge clk);
    @(negedge clk);
    d = mem_rdata; v = mem_rdata_valid;
    mem_req_valid = 1'b0;
  endtask

  task automatic drive_issue(input int s1, input int s2, input int s3, input bit u3,
                             input int d);
    issue_valid = 1'b1; issue_src1 = AW'(s1); issue_src2 = AW'(s2);
    issue_src3 = AW'(s3); issue_use_src3 = u3; issue_dst = AW'(d);
  endtask

  task automatic issue(input int s1, input int s2, input int s3, input bit u3,
                       input int d);
    sync_slot0();
    drive_issue(s1, s2, s3, u3, d);
    @(negedge clk);
    issue_valid = 1'b0;
  endtask

  task automatic expect_row(input int row, input logic [W-1:0] exp, input string req);
    logic [W-1:0] d; bit v;
    mem_store(row, d, v);
    chk(d == exp, req, d, exp);
  endtask

  task automatic t_reset_state();
    chk(issue_ready == 1'b1, "R1 ready in first cycle after reset", W'(issue_ready), W'(1));
    chk(mem_grant == 1'b0, "R10 no grant after reset", W'(mem_grant), W'(0));
    chk(mem_rdata_valid == 1'b0, "R10 no rdata_valid after reset", W'(mem_rdata_valid), W'(0));
  endtask

  task automatic t_ready_pattern();
    bit ok = 1'b1;
    logic [7:0] seen;
    for (int i = 0; i < 8; i++) begin
      seen[i] = issue_ready;
      if (issue_ready != ((i % 4) == 0)) ok = 1'b0;
      @(negedge clk);
    end
    chk(ok, "R1 ready pattern over two rotations", W'(seen), W'(8'h11));
  endtask

  task automatic t_load_store();
    logic [W-1:0] d; bit v;
    for (int r = 1; r <= 20; r++) mem_load(r, pat(r));
    mem_store(7, d, v);
    chk(d == pat(7), "R8 loaded row reads back", d, pat(7));
    chk(v == 1'b1, "R9 rdata_valid after store grant", W'(v), W'(1));
    @(negedge clk);
    chk(mem_rdata_valid == 1'b0, "R9 rdata_valid lasts one cycle", W'(mem_rdata_valid), W'(0));
  endtask

  // Third-source instruction while a store waits for slot 2
  task automatic t_src3_blocks_mem();
    int k = 0;
    bit g2;
    logic [W-1:0] d;
    sync_slot0();
    drive_issue(1, 2, 3, 1'b1, 21);
    mem_req_valid = 1'b1; mem_req_store = 1'b1; mem_req_row = AW'(4);
    @(negedge clk); k++;
    issue_valid = 1'b0;
    @(negedge clk); k++;
    g2 = mem_grant;
    chk(g2 == 1'b0, "R7 no grant while third source read", W'(g2), W'(0));
    while (!mem_grant) begin @(negedge clk); k++; end
    chk(k == 6, "R7 held request granted next free slot 2", W'(k), W'(6));
    @(negedge clk);
    d = mem_rdata;
    mem_req_valid = 1'b0;
    chk(d == pat(4), "R7 held store returns its row", d, pat(4));
    repeat (8) @(negedge clk);
    expect_row(21, madd_row(pat(1), pat(2), pat(3), 1'b1), "R3 three-source result");
  endtask

  // Two-source instruction; stores in every free slot 2 watch the write land
  task automatic t_wb_timing();
    int k = 0;
    logic [W-1:0] got [3];
    int at [3];
    sync_slot0();
    drive_issue(5, 6, 0, 1'b0, 11);
    mem_req_valid = 1'b1; mem_req_store = 1'b1; mem_req_row = AW'(11);
    @(negedge clk); k++;
    issue_valid = 1'b0;
    for (int i = 0; i < 3; i++) begin
      while (!mem_grant) begin @(negedge clk); k++; end
      at[i] = k;
      @(negedge clk); k++;
      got[i] = mem_rdata;
    end
    mem_req_valid = 1'b0;
    chk(got[0] == pat(11) && at[0] == 2, "R7 store granted during two-source instr",
        got[0], pat(11));
    chk(got[1] == pat(11) && at[1] == 6, "R4 old value before write slot", got[1], pat(11));
    chk(got[2] == madd_row(pat(5), pat(6), '0, 1'b0) && at[2] == 10,
        "R4 new value after write slot (R3 no third source)", got[2],
        madd_row(pat(5), pat(6), '0, 1'b0));
  endtask

  task automatic t_ignored_issue();
    sync_slot0();
    @(negedge clk);
    drive_issue(1, 2, 3, 1'b1, 12);
    @(negedge clk);
    @(negedge clk);
    issue_valid = 1'b0;
    repeat (12) @(negedge clk);
    expect_row(12, pat(12), "R2 issue outside slot 0 ignored");
  endtask

  task automatic t_back_to_back();
    issue(1, 2, 3, 1'b1, 13);
    issue(4, 5, 0, 1'b0, 14);
    issue(6, 7, 8, 1'b1, 15);
    repeat (12) @(negedge clk);
    expect_row(13, madd_row(pat(1), pat(2), pat(3), 1'b1), "R5 first of three");
    expect_row(14, madd_row(pat(4), pat(5), '0, 1'b0), "R5 second of three");
    expect_row(15, madd_row(pat(6), pat(7), pat(8), 1'b1), "R5 third of three");
  endtask

  // Load pushed into the slot 2 just before the result write
  task automatic t_load_next_to_wb();
    logic [W-1:0] ld = {4{64'h0F0F_1234_5678_9ABC}};
    int k = 0;
    sync_slot0();
    drive_issue(2, 3, 4, 1'b1, 16);
    mem_req_valid = 1'b1; mem_req_store = 1'b0; mem_req_row = AW'(17); mem_req_wdata = ld;
    @(negedge clk); k++;
    issue_valid = 1'b0;
    while (!mem_grant) begin @(negedge clk); k++; end
    @(negedge clk);
    mem_req_valid = 1'b0;
    chk(k == 6, "R6 load granted in slot before write slot", W'(k), W'(6));
    repeat (4) @(negedge clk);
    expect_row(17, ld, "R6 load beside write-back lands");
    expect_row(16, madd_row(pat(2), pat(3), pat(4), 1'b1), "R6 write-back beside load lands");
  endtask

  task automatic t_reset_in_flight();
    issue(9, 10, 0, 1'b0, 18);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (12) @(negedge clk);
    expect_row(18, pat(18), "R10 in-flight instruction dropped by reset");
  endtask

  initial begin
    rst_n = 1'b0;
    issue_valid = 1'b0; issue_use_src3 = 1'b0;
    issue_src1 = '0; issue_src2 = '0; issue_src3 = '0; issue_dst = '0;
    mem_req_valid = 1'b0; mem_req_store = 1'b0; mem_req_row = '0; mem_req_wdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset_state();
    t_ready_pattern();
    t_load_store();
    t_src3_blocks_mem();
    t_wb_timing();
    t_ignored_issue();
    t_back_to_back();
    t_load_next_to_wb();
    t_reset_in_flight();
    summary();
  end
endmodule